// File: doc/BRIEF.md
# Flag Offset Register Loader

This block fills the two offset registers that a FIFO's programmable flags compare against. One offset sets the almost-empty threshold (X) and one sets the almost-full threshold (Y). Each register is log2 of the FIFO depth bits wide, so a 1024-deep FIFO has 10-bit offsets.

The loading method is picked from two dual-purpose select pins while reset is held. The method is one of these:
- a preset constant, with two values to choose from;
- two qualified writes on the port-A data bus;
- a serial stream clocked in on the port-A clock.

After reset the same two pins become an active-low serial enable (`selHiSenN`) and a serial data line (`selLoSd`).

A done output rises when the selected method has completed. The surrounding FIFO holds its input-ready flag low until done is seen. After done, the offsets stay frozen until the next reset.

Top module: `ofsLoader`

## Requirements
- R1: While `rstN` is low, the block samples `{selHiSenN,selLoSd}` on every rising clock edge. Only the value sampled at the last edge before release selects the mode: 2'b00 parallel, 2'b01 preset 16, 2'b10 preset 8, 2'b11 serial.
- R2: In a preset mode, the first rising edge with `rstN` high has these effects:
  - both offsets load 8 (mode 2'b10) or 16 (mode 2'b01);
  - `loadDone` rises at that same edge.
- R3: A rising edge with `rstN` low clears both offsets to zero and drives `loadDone` low.
- R4: In parallel mode, the first rising edge with `wrEn` high loads `wrData[OFS_W-1:0]` into Y. The second such edge loads X and raises `loadDone`.
- R5: In serial mode, each rising edge with `selHiSenN` low shifts `selLoSd` into the combined register {Y,X}.
  - The first bit becomes the Y MSB and the last bit becomes the X LSB.
  - `loadDone` rises at the edge of bit 2*OFS_W (20 bits with the default depth).
- R6: Once high, `loadDone` stays high until the next reset.
- R7: After `loadDone` is high, further writes and serial bits leave both offsets unchanged.
- R8: In parallel mode, serial-enable activity changes nothing. In serial mode, `wrEn` pulses change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Port-A clock |
| rstN | input | 1 | Synchronous active-low reset; mode is sampled while low |
| selHiSenN | input | 1 | Mode select high bit in reset; active-low serial enable afterwards |
| selLoSd | input | 1 | Mode select low bit in reset; serial data afterwards |
| wrEn | input | 1 | Qualified port-A write (chip select and enable already combined) |
| wrData | input | DATA_W | Port-A data bus; low OFS_W bits used |
| xOfs | output | OFS_W | Almost-empty offset |
| yOfs | output | OFS_W | Almost-full offset |
| loadDone | output | 1 | Offsets are final |

## Verification
Serial streams are tried with these patterns, so that a wrong bit order or a missing shift shows up as different X and Y values:
- all ones in Y with a lone one in the X LSB;
- alternating bits;
- one partial stream, checked at the Y/X boundary.

Parallel loads are tried with distinct Y and X words, including all zeros against all ones, which tells apart a swapped register order from a correct one. Both preset codes are loaded, and so is a reset in which the select pins change during reset, which proves that only the last sampled code counts. Writes after done and cross-mode activity are then applied, to show they are ignored.

// File: rtl/ofs_pkg.sv
package ofs_pkg;

  typedef enum logic [1:0] {
    MODE_PAR = 2'b00,
    MODE_P16 = 2'b01,
    MODE_P8  = 2'b10,
    MODE_SER = 2'b11
  } loadMode_e;

  // Strobes from control to datapath, one cycle each
  typedef struct packed {
    logic clear;
    logic ldPreset;
    logic presetBig;
    logic ldY;
    logic ldX;
    logic shift;
  } ofsStrobe_t;

endpackage

// File: rtl/ofsCtrl.sv
module ofsCtrl
  import ofs_pkg::*;
#(
  parameter int OFS_W = 10
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       selHiSenN,
  input  logic       selLoSd,
  input  logic       wrEn,
  output ofsStrobe_t strobe,
  output loadMode_e  mode,
  output logic       done
);
  localparam int BITS  = 2 * OFS_W;
  localparam int CNT_W = $clog2(BITS + 1);

  loadMode_e        modeQ;
  logic [CNT_W-1:0] cnt;
  logic             doneQ;
  logic             active;
  logic             finish;

  always_comb begin
    active          = rstN && !doneQ;
    strobe          = '0;
    strobe.clear    = !rstN;
    strobe.presetBig = (modeQ == MODE_P16);
    strobe.ldPreset = active && ((modeQ == MODE_P8) || (modeQ == MODE_P16));
    strobe.ldY      = active && (modeQ == MODE_PAR) && wrEn && (cnt == '0);
    strobe.ldX      = active && (modeQ == MODE_PAR) && wrEn && (cnt == CNT_W'(1));
    strobe.shift    = active && (modeQ == MODE_SER) && !selHiSenN;
    finish = strobe.ldPreset || strobe.ldX ||
             (strobe.shift && (cnt == CNT_W'(BITS - 1)));
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      modeQ <= loadMode_e'({selHiSenN, selLoSd});
      cnt   <= '0;
      doneQ <= 1'b0;
    end else begin
      if (strobe.ldY || strobe.shift) cnt <= cnt + CNT_W'(1);
      if (finish) doneQ <= 1'b1;
    end
  end

  assign mode = modeQ;
  assign done = doneQ;
endmodule

// File: rtl/ofsData.sv
module ofsData
  import ofs_pkg::*;
#(
  parameter int OFS_W    = 10,
  parameter int PRESET_S = 8,
  parameter int PRESET_L = 16
) (
  input  logic             clk,
  input  ofsStrobe_t       strobe,
  input  logic             serBit,
  input  logic [OFS_W-1:0] din,
  output logic [OFS_W-1:0] xOfs,
  output logic [OFS_W-1:0] yOfs
);
  logic [OFS_W-1:0] presetVal;

  assign presetVal = strobe.presetBig ? OFS_W'(PRESET_L) : OFS_W'(PRESET_S);

  always_ff @(posedge clk) begin
    if (strobe.clear) begin
      xOfs <= '0;
      yOfs <= '0;
    end else if (strobe.ldPreset) begin
      xOfs <= presetVal;
      yOfs <= presetVal;
    end else if (strobe.ldY) begin
      yOfs <= din;
    end else if (strobe.ldX) begin
      xOfs <= din;
    end else if (strobe.shift) begin
      {yOfs, xOfs} <= {yOfs[OFS_W-2:0], xOfs, serBit};
    end
  end
endmodule

// File: rtl/ofsLoader.sv
module ofsLoader
  import ofs_pkg::*;
#(
  parameter int DEPTH    = 1024,
  parameter int DATA_W   = 36,
  parameter int PRESET_S = 8,
  parameter int PRESET_L = 16,
  localparam int OFS_W   = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              selHiSenN,
  input  logic              selLoSd,
  input  logic              wrEn,
  input  logic [DATA_W-1:0] wrData,
  output logic [OFS_W-1:0]  xOfs,
  output logic [OFS_W-1:0]  yOfs,
  output logic              loadDone
);
  ofsStrobe_t strobe;
  loadMode_e  mode;
  logic       unusedHiBits;

  assign unusedHiBits = ^wrData[DATA_W-1:OFS_W];

  ofsCtrl #(.OFS_W(OFS_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .selHiSenN(selHiSenN), .selLoSd(selLoSd),
    .wrEn(wrEn), .strobe(strobe), .mode(mode), .done(loadDone)
  );

  ofsData #(.OFS_W(OFS_W), .PRESET_S(PRESET_S), .PRESET_L(PRESET_L)) u_data (
    .clk(clk), .strobe(strobe), .serBit(selLoSd), .din(wrData[OFS_W-1:0]),
    .xOfs(xOfs), .yOfs(yOfs)
  );
endmodule

// File: rtl/ofsLoaderChk.sv
module ofsLoaderChk
  import ofs_pkg::*;
#(
  parameter int OFS_W    = 10,
  parameter int PRESET_S = 8,
  parameter int PRESET_L = 16
) (
  input logic             clk,
  input logic             rstN,
  input logic             selHiSenN,
  input logic             wrEn,
  input loadMode_e        mode,
  input logic [OFS_W-1:0] xOfs,
  input logic [OFS_W-1:0] yOfs,
  input logic             loadDone
);
  p_done_holds_r6: assert property (@(posedge clk) disable iff (!rstN)
    $past(loadDone) |-> loadDone);

  p_frozen_r7: assert property (@(posedge clk) disable iff (!rstN)
    $past(loadDone) |-> ($stable(xOfs) && $stable(yOfs)));

  p_preset_val_r2: assert property (@(posedge clk) disable iff (!rstN)
    (loadDone && mode == MODE_P8) |->
      (xOfs == OFS_W'(PRESET_S) && yOfs == OFS_W'(PRESET_S)));

  p_preset_big_r2: assert property (@(posedge clk) disable iff (!rstN)
    (loadDone && mode == MODE_P16) |->
      (xOfs == OFS_W'(PRESET_L) && yOfs == OFS_W'(PRESET_L)));

  p_par_done_r4: assert property (@(posedge clk) disable iff (!rstN)
    ($rose(loadDone) && mode == MODE_PAR) |-> $past(wrEn));

  p_ser_done_r5: assert property (@(posedge clk) disable iff (!rstN)
    ($rose(loadDone) && mode == MODE_SER) |-> !$past(selHiSenN));
endmodule

bind ofsLoader ofsLoaderChk #(.OFS_W(OFS_W), .PRESET_S(PRESET_S), .PRESET_L(PRESET_L)) u_chk (
  .clk(clk), .rstN(rstN), .selHiSenN(selHiSenN), .wrEn(wrEn), .mode(mode),
  .xOfs(xOfs), .yOfs(yOfs), .loadDone(loadDone)
);

// File: tb/sim_ofsLoader.sv
module sim_ofsLoader;
  localparam int OFS_W  = 10;
  localparam int DATA_W = 36;
  localparam int NV     = 6;
  // entry: {mode[1:0], y[9:0], x[9:0]}; preset entries give expected values
  localparam logic [21:0] VEC [NV] = '{
    {2'b11, 10'h3FF, 10'h001},
    {2'b11, 10'h2AA, 10'h155},
    {2'b00, 10'h123, 10'h3C5},
    {2'b00, 10'h000, 10'h3FF},
    {2'b10, 10'd8,   10'd8},
    {2'b01, 10'd16,  10'd16}
  };

  logic clk = 0, rstN = 0, selHiSenN = 0, selLoSd = 0, wrEn = 0;
  logic [DATA_W-1:0] wrData = '0;
  logic [OFS_W-1:0] xOfs, yOfs;
  logic loadDone;
  int checks = 0, errors = 0;
  bit finished = 0;

  ofsLoader u0 (.clk(clk), .rstN(rstN), .selHiSenN(selHiSenN), .selLoSd(selLoSd),
                .wrEn(wrEn), .wrData(wrData), .xOfs(xOfs), .yOfs(yOfs), .loadDone(loadDone));

  always #10 clk = ~clk;

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic doReset(logic [1:0] m);
    rstN = 0; {selHiSenN, selLoSd} = m; wrEn = 0;
    repeat (3) @(negedge clk);
    rstN = 1; selHiSenN = 1; selLoSd = 0;
  endtask

  task automatic serialLoad(logic [2*OFS_W-1:0] s, int nbits);
    for (int i = 2*OFS_W-1; i > 2*OFS_W-1-nbits; i--) begin
      selHiSenN = 0; selLoSd = s[i];
      @(negedge clk);
    end
    selHiSenN = 1;
  endtask

  task automatic parWrite(logic [OFS_W-1:0] d);
    wrEn = 1; wrData = {26'h2ABCDEF, d};
    @(negedge clk);
    wrEn = 0;
  endtask

  initial begin
    @(negedge clk);
    check("R3 reset x", xOfs, 0);
    check("R3 reset y", yOfs, 0);
    check("R3 reset done", loadDone, 0);

    for (int v = 0; v < NV; v++) begin
      logic [1:0] m;
      logic [OFS_W-1:0] ey, ex;
      {m, ey, ex} = VEC[v];
      doReset(m);
      if (m == 2'b11) serialLoad({ey, ex}, 2*OFS_W);
      else if (m == 2'b00) begin parWrite(ey); parWrite(ex); end
      else @(negedge clk);
      check($sformatf("R2/R4/R5 vec%0d y", v), yOfs, ey);
      check($sformatf("R2/R4/R5 vec%0d x", v), xOfs, ex);
      check($sformatf("R2/R4/R5 vec%0d done", v), loadDone, 1);
    end

    // R6 R7: writes after done ignored in parallel mode
    doReset(2'b00);
    parWrite(10'h0AA); parWrite(10'h055);
    parWrite(10'h3FF);
    selHiSenN = 0; selLoSd = 1; @(negedge clk); selHiSenN = 1;
    check("R7 y frozen", yOfs, 10'h0AA);
    check("R7 x frozen", xOfs, 10'h055);
    check("R6 done held", loadDone, 1);

    // R3: reset clears after a load
    rstN = 0; @(negedge clk);
    check("R3 clear x", xOfs, 0);
    check("R3 clear y", yOfs, 0);
    check("R3 clear done", loadDone, 0);

    // R1: select changes during reset, last sampled code wins
    rstN = 0; {selHiSenN, selLoSd} = 2'b10; repeat (2) @(negedge clk);
    {selHiSenN, selLoSd} = 2'b01; @(negedge clk);
    rstN = 1; selHiSenN = 1; selLoSd = 0; @(negedge clk);
    check("R1 last code x", xOfs, 16);
    check("R1 last code done", loadDone, 1);

    // R8: serial activity ignored in parallel mode
    doReset(2'b00);
    serialLoad(20'hFFFFF, 4);
    check("R8 par ignores serial y", yOfs, 0);
    check("R8 par ignores serial x", xOfs, 0);
    check("R4 no done before writes", loadDone, 0);
    parWrite(10'h111);
    check("R4 one write y", yOfs, 10'h111);
    check("R4 one write done", loadDone, 0);

    // R8: writes ignored in serial mode; R5 partial stream ordering
    doReset(2'b11);
    parWrite(10'h3FF);
    check("R8 ser ignores write y", yOfs, 0);
    check("R8 ser ignores write x", xOfs, 0);
    serialLoad(20'hB4000, OFS_W);
    check("R5 half stream x", xOfs, 10'h2D0);
    check("R5 half stream y", yOfs, 0);
    check("R5 half stream done", loadDone, 0);

    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(20 * 20000);
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule